// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event pulses from a set of functional units and reduces them to one level-sensitive interrupt line for the host. Each unit holds a sticky event status word and a matching event enable word. A unit's summary is the OR of its enabled status bits. At the top level, every unit's summary has an enable bit of its own. A separate software interrupt bit sits at position 31 and is not tied to any unit. A two-bit global enable can mask the unit interrupts and the software interrupt independently.

Software reaches the block through a flat register interface with one address port. A write strobe with write data programs enables, clears status bits by writing ones, and raises the software interrupt. Read data is registered and follows the address with one cycle of latency. The interrupt output is also registered.

Top module: `irqagg_ctrl`

## Requirements
- R1: After synchronous reset, all local status, local enable, top enable, global enable and software interrupt state is zero, and irq_o and rd_data_o are 0.
- R2: A 1 on evt_i bit u*EVT_W+e sets bit e of unit u's local status on the next clock edge. The bit then holds until it is cleared.
- R3: A write to unit u's local status address (4+2u) clears every bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event and a clear reach the same local status bit in the same cycle, the bit is set after that edge.
- R5: Reading address 0 returns, in bit u, the OR of unit u's local status ANDed with its local enable (address 5+2u, bits EVT_W-1:0). Bit 31 holds the software interrupt.
- R6: A unit is pending when its bit at address 0 and its top enable bit (address 1, bit u) are both 1. Any pending unit asserts irq_o while global enable bit 0 is 1.
- R7: Writing address 3 with bit 31 set raises the software interrupt. Writing address 0 with bit 31 set clears it. The software interrupt drives irq_o when top enable bit 31 and global enable bit 1 are both 1.
- R8: The global enable (address 2, bits 1:0) gates the interrupt sources: bit 0 gates the unit interrupts and bit 1 gates the software interrupt. With both bits 0, irq_o stays 0.
- R9: irq_o is registered. It changes on the clock edge after the edge that changes status or enable state.
- R10: rd_data_o presents, one clock after addr_i, the register at that address. Address 3 and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_UNITS*EVT_W | Event pulses, unit u in bits u*EVT_W +: EVT_W |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for both reads and writes |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level-sensitive host interrupt |

## Verification
Several behaviours are checked on every cycle: that an event always lands in local status, that status stays sticky unless a one is written to it, that a write-one clear takes effect, that a pending enabled source raises irq_o one edge later, and that irq_o stays low with the global enable at zero. Other behaviours can only be shown by the bench's scenarios. These are the read address map, read latency, the OR-reduction seen through address 0, the exact cycle at which irq_o rises, and the full cross-product of event position, local enables, top enable and global enable.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DATA_W      = 32;
  localparam int SWI_BIT     = 31;
  localparam int A_TSTAT     = 0;
  localparam int A_TEN       = 1;
  localparam int A_GLB       = 2;
  localparam int A_SWI       = 3;
  localparam int A_UNIT_BASE = 4;

  function automatic int lstat_addr(input int u);
    return A_UNIT_BASE + 2 * u;
  endfunction

  function automatic int len_addr(input int u);
    return A_UNIT_BASE + 2 * u + 1;
  endfunction
endpackage

// File: rtl/irqagg_unit.sv
module irqagg_unit #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             st_clr_wr_i,
  input  logic             en_wr_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] st_o,
  output logic [EVT_W-1:0] en_o,
  output logic             summary_o
);
  logic [EVT_W-1:0] clr_mask;

  assign clr_mask  = st_clr_wr_i ? wdata_i : '0;
  assign summary_o = |(st_o & en_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_o <= '0;
      en_o <= '0;
    end else begin
      st_o <= (st_o & ~clr_mask) | evt_i;
      if (en_wr_i) en_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irqagg_root.sv
module irqagg_root #(
  parameter int N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_UNITS-1:0] unit_sum_i,
  input  logic               ten_wr_i,
  input  logic               glb_wr_i,
  input  logic               swi_set_i,
  input  logic               swi_clr_i,
  input  logic [31:0]        wdata_i,
  output logic [N_UNITS-1:0] ten_unit_o,
  output logic               ten_swi_o,
  output logic [1:0]         glb_o,
  output logic               swi_o,
  output logic               irq_o
);
  logic unit_req, swi_req;

  assign unit_req = glb_o[0] & |(unit_sum_i & ten_unit_o);
  assign swi_req  = glb_o[1] & swi_o & ten_swi_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ten_unit_o <= '0;
      ten_swi_o  <= 1'b0;
      glb_o      <= 2'b00;
      swi_o      <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (ten_wr_i) begin
        ten_unit_o <= wdata_i[N_UNITS-1:0];
        ten_swi_o  <= wdata_i[31];
      end
      if (glb_wr_i) glb_o <= wdata_i[1:0];
      if (swi_set_i)      swi_o <= 1'b1;
      else if (swi_clr_i) swi_o <= 1'b0;
      irq_o <= unit_req | swi_req;
    end
  end
endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl #(
  parameter int N_UNITS = 4,
  parameter int EVT_W   = 4,
  parameter int ADDR_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_UNITS*EVT_W-1:0]   evt_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rd_data_o,
  output logic                       irq_o
);
  import irqagg_pkg::*;

  localparam int TOT_EVT = N_UNITS * EVT_W;

  logic [TOT_EVT-1:0] lst_all, len_all;
  logic [N_UNITS-1:0] unit_sum, ten_unit;
  logic               ten_swi, swi;
  logic [1:0]         glb;
  logic               wr_tstat, wr_ten, wr_glb, wr_swi;
  logic [31:0]        rd_next;

  assign wr_tstat = wr_en_i && (addr_i == ADDR_W'(A_TSTAT));
  assign wr_ten   = wr_en_i && (addr_i == ADDR_W'(A_TEN));
  assign wr_glb   = wr_en_i && (addr_i == ADDR_W'(A_GLB));
  assign wr_swi   = wr_en_i && (addr_i == ADDR_W'(A_SWI));

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic st_wr, en_wr;
    assign st_wr = wr_en_i && (addr_i == ADDR_W'(lstat_addr(u)));
    assign en_wr = wr_en_i && (addr_i == ADDR_W'(len_addr(u)));
    irqagg_unit #(.EVT_W(EVT_W)) u_unit (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (evt_i[u*EVT_W +: EVT_W]),
      .st_clr_wr_i(st_wr),
      .en_wr_i    (en_wr),
      .wdata_i    (wdata_i[EVT_W-1:0]),
      .st_o       (lst_all[u*EVT_W +: EVT_W]),
      .en_o       (len_all[u*EVT_W +: EVT_W]),
      .summary_o  (unit_sum[u])
    );
  end

  irqagg_root #(.N_UNITS(N_UNITS)) u_root (
    .clk       (clk),
    .rst       (rst),
    .unit_sum_i(unit_sum),
    .ten_wr_i  (wr_ten),
    .glb_wr_i  (wr_glb),
    .swi_set_i (wr_swi & wdata_i[SWI_BIT]),
    .swi_clr_i (wr_tstat & wdata_i[SWI_BIT]),
    .wdata_i   (wdata_i),
    .ten_unit_o(ten_unit),
    .ten_swi_o (ten_swi),
    .glb_o     (glb),
    .swi_o     (swi),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(A_TSTAT)) begin
      rd_next[N_UNITS-1:0] = unit_sum;
      rd_next[SWI_BIT]     = swi;
    end else if (addr_i == ADDR_W'(A_TEN)) begin
      rd_next[N_UNITS-1:0] = ten_unit;
      rd_next[SWI_BIT]     = ten_swi;
    end else if (addr_i == ADDR_W'(A_GLB)) begin
      rd_next[1:0] = glb;
    end
    for (int u = 0; u < N_UNITS; u++) begin
      if (addr_i == ADDR_W'(lstat_addr(u))) rd_next[EVT_W-1:0] = lst_all[u*EVT_W +: EVT_W];
      if (addr_i == ADDR_W'(len_addr(u)))   rd_next[EVT_W-1:0] = len_all[u*EVT_W +: EVT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int N_UNITS = 4,
  parameter int EVT_W   = 4,
  parameter int ADDR_W  = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_UNITS*EVT_W-1:0] evt_i,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [31:0]              wdata_i,
  input logic                     irq_o,
  input logic [N_UNITS*EVT_W-1:0] lst_all,
  input logic [N_UNITS*EVT_W-1:0] len_all,
  input logic [N_UNITS-1:0]       ten_unit,
  input logic                     ten_swi,
  input logic [1:0]               glb,
  input logic                     swi
);
  for (genvar u = 0; u < N_UNITS; u++) begin : g_u
    logic clr_hit;
    assign clr_hit = wr_en_i && (addr_i == ADDR_W'(irqagg_pkg::lstat_addr(u)));

    AST_UNIT_PEND: assert property (@(posedge clk) disable iff (rst)
      (glb[0] && ten_unit[u] && |(lst_all[u*EVT_W +: EVT_W] & len_all[u*EVT_W +: EVT_W])) |=> irq_o); // R6

    for (genvar e = 0; e < EVT_W; e++) begin : g_e
      AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        evt_i[u*EVT_W+e] |=> lst_all[u*EVT_W+e]); // R4
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lst_all[u*EVT_W+e] && !(clr_hit && wdata_i[e])) |=> lst_all[u*EVT_W+e]); // R2
      AST_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && wdata_i[e] && !evt_i[u*EVT_W+e]) |=> !lst_all[u*EVT_W+e]); // R3
    end
  end

  AST_GLB_OFF: assert property (@(posedge clk) disable iff (rst)
    (glb == 2'b00) |=> !irq_o); // R8
  AST_SWI_PEND: assert property (@(posedge clk) disable iff (rst)
    (glb[1] && swi && ten_swi) |=> irq_o); // R7
endmodule

bind irqagg_ctrl irqagg_chk #(.N_UNITS(N_UNITS), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .lst_all(lst_all), .len_all(len_all),
  .ten_unit(ten_unit), .ten_swi(ten_swi), .glb(glb), .swi(swi)
);

// File: tb/sim_irqagg_ctrl.sv
module sim_irqagg_ctrl;
  localparam int N  = 3;
  localparam int E  = 2;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*E-1:0] evt = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_data;
  logic          irq;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  irqagg_ctrl #(.N_UNITS(N), .EVT_W(E), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = AW'(a);
    @(negedge clk); d = rd_data;
  endtask

  task automatic pulse(input int b);
    @(negedge clk); evt = '0; evt[b] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd(0, d); chk("R1 tstat", d, 0);
    rd(1, d); chk("R1 ten", d, 0);
    rd(2, d); chk("R1 glb", d, 0);
    for (int u = 0; u < N; u++) begin
      rd(4+2*u, d); chk("R1 lstat", d, 0);
      rd(5+2*u, d); chk("R1 len", d, 0);
    end

    // Sweep: R2 R5 R6 R8 R10
    for (int u = 0; u < N; u++)
      for (int e = 0; e < E; e++)
        for (int lp = 0; lp < (1 << E); lp++)
          for (int te = 0; te < 2; te++)
            for (int g = 0; g < 4; g++) begin
              logic sum, exp_irq;
              sum = lp[e];
              exp_irq = g[0] & sum & te[0];
              wr(5+2*u, 32'(lp));
              wr(1, 32'(te) << u);
              wr(2, 32'(g));
              pulse(u*E+e);
              @(negedge clk);
              chk("R6 R8 irq", {31'b0, irq}, {31'b0, exp_irq});
              rd(4+2*u, d); chk("R2 lstat", d, 32'(1) << e);
              rd(0, d);     chk("R5 tstat", d, 32'(sum) << u);
              rd(5+2*u, d); chk("R10 len", d, 32'(lp));
              wr(4+2*u, 32'hFFFF_FFFF);
              rd(4+2*u, d); chk("R3 cleared", d, 0);
            end

    // R3: writing 0 leaves bits alone
    pulse(1); pulse(0);
    wr(4, 32'h0);
    rd(4, d); chk("R3 write0", d, 32'h3);
    wr(4, 32'h1);
    rd(4, d); chk("R3 partial", d, 32'h2);
    wr(4, 32'h3);

    // R4: event and clear in the same cycle
    @(negedge clk); evt = '0; evt[0] = 1'b1; wr_en = 1'b1; addr = AW'(4); wdata = 32'h1;
    @(negedge clk); evt = '0; wr_en = 1'b0; wdata = '0;
    rd(4, d); chk("R4 set wins", d, 32'h1);
    wr(4, 32'h3);

    // R9: irq latency
    wr(7, 32'h1); wr(1, 32'h2); wr(2, 32'h1);
    @(negedge clk); evt = '0; evt[E] = 1'b1;
    @(negedge clk); evt = '0;
    chk("R9 not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R9 risen", {31'b0, irq}, 1);
    wr(6, 32'h1);
    chk("R9 still high", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R9 fallen", {31'b0, irq}, 0);

    // R7 software interrupt
    wr(1, 32'h8000_0000); wr(2, 32'h2);
    wr(3, 32'h8000_0000);
    rd(0, d); chk("R7 swi status", d, 32'h8000_0000);
    chk("R7 swi irq", {31'b0, irq}, 1);
    wr(2, 32'h1); @(negedge clk);
    chk("R8 swi masked", {31'b0, irq}, 0);
    wr(2, 32'h3); wr(1, 32'h0); @(negedge clk);
    chk("R7 top enable off", {31'b0, irq}, 0);
    rd(3, d); chk("R10 swi addr reads 0", d, 0);
    wr(0, 32'h8000_0000);
    rd(0, d); chk("R7 swi cleared", d, 0);
    rd(40, d); chk("R10 unused", d, 0);
    rd(2, d); chk("R10 glb", d, 32'h3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule